// File: doc/BRIEF.md
# FIFO-level DMA request and panic generator

This block watches the fill levels of a transmit FIFO and a receive FIFO and tells an external DMA engine when each side needs service. For each direction it raises a request line and a panic line. The panic line asks the engine to give that direction higher priority. Four 8-bit thresholds set the trip points, and all four are loaded through a single 32-bit configuration write.

The two directions use opposite comparisons. The transmit side raises its lines when the FIFO has drained to its threshold or below. The receive side raises its lines when the FIFO has filled past its threshold. The receive request also stays up after a transfer has finished, as long as any data is left in the receive FIFO, so that the tail gets drained. Every output is registered, and all of them are forced low while DMA is disabled.

Top module: `fifo_dma_req`

## Requirements
- R1: During and after reset, all four outputs are low. The thresholds start at 0x30 for receive panic, 0x20 for receive request, 0x10 for transmit panic and 0x20 for transmit request.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_wdata` loads all thresholds: receive panic from bits [31:24], receive request from [23:16], transmit panic from [15:8] and transmit request from [7:0].
- R3: `rx_panic` is high when `rx_level` is strictly greater than the receive panic threshold (unsigned).
- R4: `rx_req` is high when `rx_level` is strictly greater than the receive request threshold (unsigned).
- R5: `rx_req` is also high when `xfer_done` is high and `rx_level` is nonzero, whatever the threshold.
- R6: `tx_panic` is high when `tx_level` is less than or equal to the transmit panic threshold (unsigned).
- R7: `tx_req` is high when `tx_level` is less than or equal to the transmit request threshold (unsigned).
- R8: Each output reflects the inputs and thresholds present at the previous rising edge. A change in an input does not appear on the outputs before the next edge.
- R9: While `dma_en` is low, all four outputs are low one edge later, whatever the levels.
- R10: A value on `cfg_wdata` while `cfg_we` is low has no effect on the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | DMA enable; when low, all outputs are low |
| tx_level | input | 8 | Transmit FIFO fill level |
| rx_level | input | 8 | Receive FIFO fill level |
| xfer_done | input | 1 | Transfer finished flag |
| cfg_we | input | 1 | Threshold register write strobe |
| cfg_wdata | input | 32 | Threshold register write data |
| tx_req | output | 1 | Transmit DMA request |
| tx_panic | output | 1 | Transmit priority raise |
| rx_req | output | 1 | Receive DMA request |
| rx_panic | output | 1 | Receive priority raise |

## Verification
The hardest cases to reach are the exact-threshold boundaries: a level equal to a threshold, one above it and one below it. Uniform random 8-bit levels land on these points only rarely. The stimulus therefore chooses many levels as the current modelled threshold plus -1, 0 or +1, and it also rewrites the thresholds at random so that the boundaries move. Directed steps cover the remaining boundaries:
- thresholds of 0x00 and 0xFF;
- the end-of-transfer drain with a level of exactly one and with a level of zero;
- a write of garbage data with the strobe low.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

    localparam int LVL_W = 8;

    typedef logic [LVL_W-1:0] level_t;

    // Field order matches the 32-bit write layout from MSB down.
    typedef struct packed {
        level_t rx_panic;
        level_t rx_req;
        level_t tx_panic;
        level_t tx_req;
    } thresh_t;

    localparam int CFG_W = $bits(thresh_t);

    localparam thresh_t THRESH_RST = '{
        rx_panic: 8'h30,
        rx_req:   8'h20,
        tx_panic: 8'h10,
        tx_req:   8'h20
    };

    typedef struct packed {
        logic tx_req;
        logic tx_panic;
        logic rx_req;
        logic rx_panic;
    } dma_sig_t;

    function automatic logic fill_above(level_t lvl, level_t thr);
        return lvl > thr;
    endfunction

    function automatic logic drain_at_or_below(level_t lvl, level_t thr);
        return lvl <= thr;
    endfunction

endpackage

// File: rtl/dmareq_thresh_reg.sv
module dmareq_thresh_reg
    import dmareq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output thresh_t          thr
);
    always_ff @(posedge clk) begin
        if (rst)
            thr <= THRESH_RST;
        else if (we)
            thr <= thresh_t'(wdata);
    end
endmodule

// File: rtl/dmareq_level_cmp.sv
module dmareq_level_cmp
    import dmareq_pkg::*;
#(
    parameter bit FILL_SIDE = 1'b1
) (
    input  level_t lvl,
    input  level_t thr,
    output logic   hit
);
    generate
        if (FILL_SIDE) begin : g_fill
            assign hit = fill_above(lvl, thr);
        end else begin : g_drain
            assign hit = drain_at_or_below(lvl, thr);
        end
    endgenerate
endmodule

// File: rtl/fifo_dma_req.sv
module fifo_dma_req
    import dmareq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dma_en,
    input  logic [7:0]  tx_level,
    input  logic [7:0]  rx_level,
    input  logic        xfer_done,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic        tx_req,
    output logic        tx_panic,
    output logic        rx_req,
    output logic        rx_panic
);
    thresh_t  thr;
    dma_sig_t hit;
    dma_sig_t nxt;
    dma_sig_t q;
    logic     rx_tail;

    dmareq_thresh_reg u_thr (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .thr   (thr)
    );

    dmareq_level_cmp #(.FILL_SIDE(1'b1)) u_rxp (
        .lvl(rx_level), .thr(thr.rx_panic), .hit(hit.rx_panic));
    dmareq_level_cmp #(.FILL_SIDE(1'b1)) u_rxr (
        .lvl(rx_level), .thr(thr.rx_req),   .hit(hit.rx_req));
    dmareq_level_cmp #(.FILL_SIDE(1'b0)) u_txp (
        .lvl(tx_level), .thr(thr.tx_panic), .hit(hit.tx_panic));
    dmareq_level_cmp #(.FILL_SIDE(1'b0)) u_txr (
        .lvl(tx_level), .thr(thr.tx_req),   .hit(hit.tx_req));

    assign rx_tail = xfer_done && (rx_level != '0);

    always_comb begin
        nxt = '0;
        if (dma_en) begin
            nxt          = hit;
            nxt.rx_req   = hit.rx_req | rx_tail;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    assign tx_req   = q.tx_req;
    assign tx_panic = q.tx_panic;
    assign rx_req   = q.rx_req;
    assign rx_panic = q.rx_panic;
endmodule

// File: rtl/dmareq_chk.sv
module dmareq_chk
    import dmareq_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    dma_en,
    input level_t  tx_level,
    input level_t  rx_level,
    input logic    xfer_done,
    input thresh_t thr,
    input logic    tx_req,
    input logic    tx_panic,
    input logic    rx_req,
    input logic    rx_panic
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R9
    dis_quiet_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(!dma_en) |-> !(tx_req || tx_panic || rx_req || rx_panic));

    // R5
    rx_tail_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(dma_en && xfer_done && rx_level != '0) |-> rx_req);

    // R3
    rx_panic_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        rx_panic == $past(dma_en && (rx_level > thr.rx_panic)));

    // R6
    tx_panic_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        tx_panic == $past(dma_en && (tx_level <= thr.tx_panic)));

    // R7
    tx_req_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        tx_req == $past(dma_en && (tx_level <= thr.tx_req)));

    // R4
    rx_req_lvl_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(dma_en && (rx_level > thr.rx_req)) |-> rx_req);
endmodule

bind fifo_dma_req dmareq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dma_en    (dma_en),
    .tx_level  (tx_level),
    .rx_level  (rx_level),
    .xfer_done (xfer_done),
    .thr       (thr),
    .tx_req    (tx_req),
    .tx_panic  (tx_panic),
    .rx_req    (rx_req),
    .rx_panic  (rx_panic)
);

// File: tb/sim_fifo_dma_req.sv
module sim_fifo_dma_req;
    logic        clk = 1'b0;
    logic        rst;
    logic        dma_en;
    logic [7:0]  tx_level, rx_level;
    logic        xfer_done, cfg_we;
    logic [31:0] cfg_wdata;
    logic        tx_req, tx_panic, rx_req, rx_panic;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    logic [31:0] thr_m;
    logic [3:0]  exp_q;   // {tx_req, tx_panic, rx_req, rx_panic}
    logic [3:0]  exp_prev;

    always #4 clk = ~clk;

    fifo_dma_req u0 (
        .clk(clk), .rst(rst), .dma_en(dma_en),
        .tx_level(tx_level), .rx_level(rx_level), .xfer_done(xfer_done),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tx_req(tx_req), .tx_panic(tx_panic), .rx_req(rx_req), .rx_panic(rx_panic)
    );

    function automatic logic [3:0] model(logic en, logic [7:0] tl, logic [7:0] rl,
                                         logic dn, logic [31:0] t);
        logic [3:0] r;
        r[3] = en && (tl <= t[7:0]);
        r[2] = en && (tl <= t[15:8]);
        r[1] = en && ((rl > t[23:16]) || (dn && rl != 8'd0));
        r[0] = en && (rl > t[31:24]);
        return r;
    endfunction

    task automatic cmp(logic act, logic expv, string req);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b (tx=%0h rx=%0h thr=%08h)",
                     req, act, expv, tx_level, rx_level, thr_m);
        end
    endtask

    task automatic check_all(logic [3:0] e, string tag);
        string tr, tp, rr, rp;
        tr = (tag != "") ? tag : (dma_en ? "R7" : "R9");
        tp = (tag != "") ? tag : (dma_en ? "R6" : "R9");
        rr = (tag != "") ? tag : (dma_en ? (xfer_done ? "R5" : "R4") : "R9");
        rp = (tag != "") ? tag : (dma_en ? "R3" : "R9");
        cmp(tx_req,   e[3], tr);
        cmp(tx_panic, e[2], tp);
        cmp(rx_req,   e[1], rr);
        cmp(rx_panic, e[0], rp);
    endtask

    // Called at a falling edge: drive, confirm no early change (R8), clock, check.
    task automatic step(logic en, logic [7:0] tl, logic [7:0] rl, logic dn,
                        logic we, logic [31:0] wd, string tag);
        dma_en = en; tx_level = tl; rx_level = rl; xfer_done = dn;
        cfg_we = we; cfg_wdata = wd;
        exp_q = model(en, tl, rl, dn, thr_m);
        #1;
        check_all(exp_prev, "R8");
        @(posedge clk);
        if (we) thr_m = wd;
        @(negedge clk);
        check_all(exp_q, tag);
        exp_prev = exp_q;
    endtask

    initial begin
        #1_000_000;
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        rst = 1'b1; dma_en = 1'b1; tx_level = 8'd0; rx_level = 8'hFF;
        xfer_done = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        thr_m = 32'h3020_1020;
        repeat (3) @(negedge clk);
        check_all(4'b0000, "R1");
        @(posedge clk); rst = 1'b0;
        @(negedge clk);
        exp_prev = model(dma_en, tx_level, rx_level, xfer_done, thr_m);
        check_all(exp_prev, "R1");

        // R1 reset thresholds at their boundaries
        step(1, 8'h20, 8'h20, 0, 0, 0, "R1");
        step(1, 8'h21, 8'h21, 0, 0, 0, "R1");
        step(1, 8'h10, 8'h30, 0, 0, 0, "R1");
        step(1, 8'h11, 8'h31, 0, 0, 0, "R1");
        // R10 garbage data with strobe low
        step(1, 8'h20, 8'h21, 0, 0, 32'h0000_FFFF, "R10");
        step(1, 8'h21, 8'h31, 0, 0, 32'hFFFF_0000, "R10");
        // R2 field layout
        step(1, 8'h00, 8'h00, 0, 1, 32'h8040_0A05, "R2");
        step(1, 8'h05, 8'h41, 0, 0, 0, "R2");
        step(1, 8'h0A, 8'h80, 0, 0, 0, "R2");
        step(1, 8'h06, 8'h81, 0, 0, 0, "R2");
        // extremes: rx thresholds 0xFF, tx thresholds 0x00
        step(1, 8'h00, 8'h00, 0, 1, 32'hFFFF_0000, "");
        step(1, 8'h00, 8'hFF, 0, 0, 0, "");
        step(1, 8'h01, 8'hFF, 0, 0, 0, "");
        // R5 drain tail
        step(1, 8'h01, 8'h01, 1, 0, 0, "R5");
        step(1, 8'h01, 8'h00, 1, 0, 0, "R5");
        step(1, 8'h01, 8'h01, 0, 0, 0, "R5");
        // R9 disabled
        step(0, 8'h00, 8'hFF, 1, 1, 32'h0000_FFFF, "R9");
        step(0, 8'h00, 8'hFF, 1, 0, 0, "R9");
        step(1, 8'h00, 8'hFF, 1, 0, 0, "");

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] tl, rl;
            logic en, dn, we;
            logic [31:0] wd;
            int sel;
            sel = $urandom_range(0, 3);
            tl = 8'($urandom);
            rl = 8'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                case (sel)
                    0: tl = thr_m[7:0]   + 8'($urandom_range(0, 2)) - 8'd1;
                    1: tl = thr_m[15:8]  + 8'($urandom_range(0, 2)) - 8'd1;
                    2: rl = thr_m[23:16] + 8'($urandom_range(0, 2)) - 8'd1;
                    default: rl = thr_m[31:24] + 8'($urandom_range(0, 2)) - 8'd1;
                endcase
            end
            en = ($urandom_range(0, 9) != 0);
            dn = ($urandom_range(0, 3) == 0);
            we = ($urandom_range(0, 15) == 0);
            wd = $urandom;
            step(en, tl, rl, dn, we, wd, "");
        end

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule